// File: doc/BRIEF.md
# Byte-Serial Command Frame Deserializer

This block accepts register-write commands that arrive one byte per clock on an 8-bit bus and turns each one into a single parallel write. A command frame is six bytes long: two address bytes, low byte first, followed by four data bytes. A start marker is raised with the first byte of a frame only, and the remaining bytes follow on consecutive clocks with the marker low.

Once the last data byte arrives, the assembled 16-bit address is tested against a base address under a mask. Only the address bits selected by the mask take part in the test. With the default base 0x0710 and mask 0x07FC, the block answers to a window of four consecutive addresses. On a hit, the block presents a 2-bit local register index taken from the lowest address bits, the 32-bit data word and a write strobe lasting one clock. A register file or a set of control flops next to the block consumes these.

A new start marker in the middle of a frame drops the partial frame and begins a new one. The reset is synchronous to the clock.

Top module: `cmd_frame_deser`

## Requirements
- R1: While `srst` is high at a rising edge, the next cycle shows `wr_en`=0, `wr_idx`=0 and `wr_data`=0.
- R2: Frame byte order is address bits 7:0, then address bits 15:8, then data bytes 0 to 3. The data word is little-endian, so data byte 0 lands in `wr_data[7:0]` and data byte 3 in `wr_data[31:24]`.
- R3: A frame is accepted when (address AND 0x07FC) equals (0x0710 AND 0x07FC). On acceptance, `wr_idx` equals address bits 1:0. Address bits outside the mask, such as bit 11, do not affect the decision.
- R4: A frame whose masked address differs, for example 0x0714 or 0x0610, produces no `wr_en`.
- R5: `wr_en` is high for exactly one cycle: the cycle right after the edge that captures the sixth byte.
- R6: Bytes presented while no frame is open and `in_first` is low are ignored and produce no write.
- R7: `in_first` arriving while a frame is partly received restarts collection, and that byte is taken as the new address low byte.
- R8: `wr_idx` and `wr_data` change only at an accepted write and hold their values otherwise, including through rejected frames.
- R9: A reset in the middle of a frame discards it. Bytes that follow without a new `in_first` produce no write.
- R10: A new frame may start in the same cycle that `wr_en` of the previous frame is high, and both frames are written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| srst | input | 1 | Synchronous reset, active high |
| in_byte | input | 8 | Serial command byte |
| in_first | input | 1 | Marks the first byte of a frame |
| wr_idx | output | 2 | Local register index of the accepted write |
| wr_data | output | 32 | Data word of the accepted write |
| wr_en | output | 1 | One-cycle write strobe |

## Verification
The assertions assume that the source never starts a frame more often than once every six cycles. They also assume that, once a frame has begun, its bytes arrive on consecutive clocks until the sixth or until a restart. The assertions count cycles from the last `in_first` and expect the write strobe exactly six cycles later. The directed tasks keep to this: they drive one byte on every falling edge with no gaps, and they raise `in_first` early only in the restart scenario, where the partial frame is deliberately abandoned. Stray bytes and a mid-frame reset are driven with `in_first` low, so they never form a frame that the counters would misread.

// File: rtl/cfd_pkg.sv
package cfd_pkg;
   // frame collector state: waiting for a start marker, or inside a frame
   typedef enum logic {
      CFD_IDLE    = 1'b0,
      CFD_COLLECT = 1'b1
   } cfd_state_e;
endpackage

// File: rtl/cfd_collector.sv
module cfd_collector
   import cfd_pkg::*;
#(
   parameter int BYTE_W    = 8,
   parameter int FRAME_LEN = 6
)(
   input  logic                        clk,
   input  logic                        srst,
   input  logic [BYTE_W-1:0]           in_byte,
   input  logic                        in_first,
   output logic [FRAME_LEN*BYTE_W-1:0] frame_bus,
   output logic                        frame_fire
);
   localparam int POS_W = (FRAME_LEN > 2) ? $clog2(FRAME_LEN) : 1;
   localparam int LAST  = FRAME_LEN - 1;

   cfd_state_e                      state_q;
   logic [POS_W-1:0]                pos_q;
   logic [POS_W-1:0]                slot_sel;
   logic                            take;
   logic [FRAME_LEN-2:0][BYTE_W-1:0] slot_q;

   assign take       = in_first || (state_q == CFD_COLLECT);
   assign slot_sel   = in_first ? '0 : pos_q;
   assign frame_fire = !in_first && (state_q == CFD_COLLECT) && (pos_q == POS_W'(LAST));

   always_ff @(posedge clk) begin
      if (srst) begin
         state_q <= CFD_IDLE;
         pos_q   <= '0;
      end else if (in_first) begin
         state_q <= CFD_COLLECT;
         pos_q   <= POS_W'(1);
      end else if (state_q == CFD_COLLECT) begin
         if (pos_q == POS_W'(LAST)) begin
            state_q <= CFD_IDLE;
            pos_q   <= '0;
         end else begin
            pos_q <= pos_q + POS_W'(1);
         end
      end
   end

   // one holding slot per byte except the last, which is used live
   for (genvar k = 0; k < FRAME_LEN - 1; k++) begin : g_slot
      always_ff @(posedge clk) begin
         if (srst)
            slot_q[k] <= '0;
         else if (take && (slot_sel == POS_W'(k)))
            slot_q[k] <= in_byte;
      end
   end

   assign frame_bus = {in_byte, slot_q};
endmodule

// File: rtl/cfd_addr_match.sv
module cfd_addr_match #(
   parameter int                ADDR_W = 16,
   parameter logic [ADDR_W-1:0] BASE   = 16'h0710,
   parameter logic [ADDR_W-1:0] MASK   = 16'h07FC
)(
   input  logic [ADDR_W-1:0] addr,
   output logic              hit
);
   if (MASK == '0) begin : g_open
      // empty mask: every address is inside the window
      assign hit = 1'b1;
   end else begin : g_cmp
      assign hit = (((addr ^ BASE) & MASK) == '0);
   end
endmodule

// File: rtl/cmd_frame_deser.sv
module cmd_frame_deser #(
   parameter int          BYTE_W     = 8,
   parameter int          ADDR_BYTES = 2,
   parameter int          DATA_BYTES = 4,
   parameter int          IDX_W      = 2,
   parameter logic [31:0] BASE_ADDR  = 32'h0000_0710,
   parameter logic [31:0] ADDR_MASK  = 32'h0000_07FC
)(
   input  logic                         clk,
   input  logic                         srst,
   input  logic [BYTE_W-1:0]            in_byte,
   input  logic                         in_first,
   output logic [IDX_W-1:0]             wr_idx,
   output logic [DATA_BYTES*BYTE_W-1:0] wr_data,
   output logic                         wr_en
);
   localparam int ADDR_W    = ADDR_BYTES * BYTE_W;
   localparam int DATA_W    = DATA_BYTES * BYTE_W;
   localparam int FRAME_LEN = ADDR_BYTES + DATA_BYTES;
   localparam int FRAME_W   = FRAME_LEN * BYTE_W;

   if (BYTE_W < 1) begin : g_bad_byte
      $error("BYTE_W must be at least 1");
   end
   if (ADDR_BYTES < 1 || ADDR_W > 32) begin : g_bad_addr
      $error("address must be 1 byte to 32 bits");
   end
   if (DATA_BYTES < 1) begin : g_bad_data
      $error("DATA_BYTES must be at least 1");
   end
   if (IDX_W < 1 || IDX_W > ADDR_W) begin : g_bad_idx
      $error("IDX_W must fit inside the address");
   end

   logic [FRAME_W-1:0] frame_bus;
   logic               frame_fire;
   logic [ADDR_W-1:0]  frame_addr;
   logic [DATA_W-1:0]  frame_data;
   logic               addr_hit;

   cfd_collector #(
      .BYTE_W    (BYTE_W),
      .FRAME_LEN (FRAME_LEN)
   ) i_collect (
      .clk        (clk),
      .srst       (srst),
      .in_byte    (in_byte),
      .in_first   (in_first),
      .frame_bus  (frame_bus),
      .frame_fire (frame_fire)
   );

   assign frame_addr = frame_bus[ADDR_W-1:0];
   assign frame_data = frame_bus[FRAME_W-1 -: DATA_W];

   cfd_addr_match #(
      .ADDR_W (ADDR_W),
      .BASE   (BASE_ADDR[ADDR_W-1:0]),
      .MASK   (ADDR_MASK[ADDR_W-1:0])
   ) i_match (
      .addr (frame_addr),
      .hit  (addr_hit)
   );

   always_ff @(posedge clk) begin
      if (srst) begin
         wr_en   <= 1'b0;
         wr_idx  <= '0;
         wr_data <= '0;
      end else begin
         wr_en <= frame_fire && addr_hit;
         if (frame_fire && addr_hit) begin
            wr_idx  <= frame_addr[IDX_W-1:0];
            wr_data <= frame_data;
         end
      end
   end
endmodule

// File: rtl/cfd_checker.sv
module cfd_checker #(
   parameter int BYTE_W    = 8,
   parameter int FRAME_LEN = 6,
   parameter int IDX_W     = 2,
   parameter int DATA_W    = 32
)(
   input logic              clk,
   input logic              srst,
   input logic [BYTE_W-1:0] in_byte,
   input logic              in_first,
   input logic [IDX_W-1:0]  wr_idx,
   input logic [DATA_W-1:0] wr_data,
   input logic              wr_en
);
   localparam int CNT_W = $clog2(FRAME_LEN + 2);

   logic [CNT_W-1:0]  since_q;
   logic [BYTE_W-1:0] lo_q;
   logic              armed_q;

   always_ff @(posedge clk) begin
      if (srst) begin
         since_q <= '0;
         lo_q    <= '0;
         armed_q <= 1'b0;
      end else begin
         armed_q <= 1'b1;
         if (in_first) begin
            since_q <= CNT_W'(1);
            lo_q    <= in_byte;
         end else if (since_q != '0 && since_q <= CNT_W'(FRAME_LEN)) begin
            since_q <= since_q + CNT_W'(1);
         end
      end
   end

   assert_reset_clear_R1: assert property (@(posedge clk)
      srst |=> (!wr_en && wr_idx == '0 && wr_data == '0));

   assert_idx_from_addr_R3: assert property (@(posedge clk) disable iff (srst)
      wr_en |-> (wr_idx == lo_q[IDX_W-1:0]));

   assert_single_pulse_R5: assert property (@(posedge clk) disable iff (srst)
      wr_en |=> !wr_en);

   // also covers R6: a write needs a start marker exactly one frame earlier
   assert_frame_timing_R7: assert property (@(posedge clk) disable iff (srst)
      wr_en |-> (since_q == CNT_W'(FRAME_LEN)));

   assert_outputs_hold_R8: assert property (@(posedge clk) disable iff (srst)
      (armed_q && !wr_en) |-> ($stable(wr_idx) && $stable(wr_data)));
endmodule

bind cmd_frame_deser cfd_checker #(
   .BYTE_W    (BYTE_W),
   .FRAME_LEN (FRAME_LEN),
   .IDX_W     (IDX_W),
   .DATA_W    (DATA_W)
) i_cfd_checker (
   .clk      (clk),
   .srst     (srst),
   .in_byte  (in_byte),
   .in_first (in_first),
   .wr_idx   (wr_idx),
   .wr_data  (wr_data),
   .wr_en    (wr_en)
);

// File: tb/test_cmd_frame_deser.sv
`timescale 1ns/1ps
module test_cmd_frame_deser;
   logic        clk = 1'b0;
   logic        srst = 1'b1;
   logic [7:0]  in_byte = '0;
   logic        in_first = 1'b0;
   logic [1:0]  wr_idx;
   logic [31:0] wr_data;
   logic        wr_en;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   always #4 clk = ~clk;

   cmd_frame_deser i_cmd_frame_deser (
      .clk(clk), .srst(srst), .in_byte(in_byte), .in_first(in_first),
      .wr_idx(wr_idx), .wr_data(wr_data), .wr_en(wr_en)
   );

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic drive(logic [7:0] b, logic first);
      @(negedge clk);
      in_byte  = b;
      in_first = first;
   endtask

   task automatic idle();
      in_byte  = 8'h00;
      in_first = 1'b0;
   endtask

   // drives one six-byte frame; if chain is set, the strobe of the previous
   // frame is checked on the cycle this frame starts
   task automatic send_frame(logic [15:0] a, logic [31:0] d, bit chain);
      @(negedge clk);
      if (chain) check("R10 strobe of earlier frame", {31'b0, wr_en}, 32'd1);
      in_byte = a[7:0]; in_first = 1'b1;
      drive(a[15:8], 1'b0);
      for (int k = 0; k < 4; k++) drive(d[8*k +: 8], 1'b0);
   endtask

   // samples the cycle after the last byte, then the one after that
   task automatic expect_write(string req, bit en, logic [1:0] idx, logic [31:0] data);
      @(negedge clk);
      check({req, " wr_en"}, {31'b0, wr_en}, {31'b0, en});
      check({req, " wr_idx"}, {30'b0, wr_idx}, {30'b0, idx});
      check({req, " wr_data"}, wr_data, data);
      idle();
      @(negedge clk);
      check("R5 strobe lasts one cycle", {31'b0, wr_en}, 32'd0);
   endtask

   task automatic t_reset();
      repeat (3) @(negedge clk);
      check("R1 wr_en", {31'b0, wr_en}, 32'd0);
      check("R1 wr_idx", {30'b0, wr_idx}, 32'd0);
      check("R1 wr_data", wr_data, 32'd0);
      srst = 1'b0;
   endtask

   task automatic t_basic();
      send_frame(16'h0710, 32'h1122_3344, 1'b0);
      expect_write("R2 R3 base address", 1'b1, 2'd0, 32'h1122_3344);
      send_frame(16'h0713, 32'hA5C3_0F81, 1'b0);
      expect_write("R2 R3 top of window", 1'b1, 2'd3, 32'hA5C3_0F81);
      send_frame(16'h0F12, 32'h0BAD_F00D, 1'b0);
      expect_write("R3 unmasked bit ignored", 1'b1, 2'd2, 32'h0BAD_F00D);
   endtask

   task automatic t_reject();
      send_frame(16'h0714, 32'hDEAD_BEEF, 1'b0);
      expect_write("R4 R8 above window", 1'b0, 2'd2, 32'h0BAD_F00D);
      send_frame(16'h0610, 32'h1234_5678, 1'b0);
      expect_write("R4 R8 other page", 1'b0, 2'd2, 32'h0BAD_F00D);
   endtask

   task automatic t_stray();
      int seen = 0;
      for (int k = 0; k < 10; k++) begin
         drive(8'h10 + 8'(k), 1'b0);
         if (wr_en) seen++;
      end
      @(negedge clk); idle();
      if (wr_en) seen++;
      check("R6 stray bytes write count", 32'(seen), 32'd0);
      check("R6 R8 data held", wr_data, 32'h0BAD_F00D);
   endtask

   task automatic t_restart();
      int seen = 0;
      @(negedge clk); in_byte = 8'h14; in_first = 1'b1;
      drive(8'h07, 1'b0);
      drive(8'hEE, 1'b0);
      if (wr_en) seen++;
      send_frame(16'h0711, 32'hCAFE_0001, 1'b0);
      expect_write("R7 restarted frame", 1'b1, 2'd1, 32'hCAFE_0001);
      check("R7 no write from dropped frame", 32'(seen), 32'd0);
   endtask

   task automatic t_mid_reset();
      @(negedge clk); in_byte = 8'h12; in_first = 1'b1;
      drive(8'h07, 1'b0);
      drive(8'h55, 1'b0);
      @(negedge clk); srst = 1'b1; idle();
      @(negedge clk);
      @(negedge clk); srst = 1'b0;
      drive(8'h66, 1'b0);
      drive(8'h77, 1'b0);
      drive(8'h88, 1'b0);
      @(negedge clk); idle();
      check("R9 no write after reset", {31'b0, wr_en}, 32'd0);
      check("R9 data cleared", wr_data, 32'd0);
      @(negedge clk);
      check("R9 still no write", {31'b0, wr_en}, 32'd0);
   endtask

   task automatic t_back_to_back();
      send_frame(16'h0712, 32'h0102_0304, 1'b0);
      send_frame(16'h0710, 32'hF0E0_D0C0, 1'b1);
      expect_write("R10 second frame", 1'b1, 2'd0, 32'hF0E0_D0C0);
   endtask

   initial begin
      t_reset();
      t_basic();
      t_reject();
      t_stray();
      t_restart();
      t_mid_reset();
      t_back_to_back();
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule